// File: doc/BRIEF.md
# Periodic Interrupt Timer with Two-Stage Divider

This block raises a periodic interrupt request from the free-running oscillator clock. The clock goes through two divider stages. A coarse prescaler divides by a power of two, and a fine modulus stage then divides by a small integer. Software sets both ratios through one byte-wide control register. Every write to that register restarts both stages from zero. The request is held in a sticky flag, and software drops the flag with a one-cycle clear pulse.

The block has a low-power hold mode. When the pseudo-stop input is high and the run-in-stop bit is 0, both divider stages freeze and keep their current counts. When pseudo-stop ends, counting resumes from the held counts. The run-in-stop bit is a separate one-bit setting with its own write strobe. When that bit is 1, the timer keeps counting through pseudo-stop.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset, the control value is 0, the run-in-stop bit is 0 and the interrupt flag is 0.
- R2: A write stores control bits 6:4 as the prescale select and bits 3:0 as the modulus select. While the read strobe is high, the read data is {0, prescale select, modulus select}, so bit 7 always reads 0. While the read strobe is low, the read data is 0.
- R3: Every control write restarts both stages. The next flag therefore appears one full period after the clock edge that takes the write, and earlier progress is discarded.
- R4: A prescale select of 0 disables the timer. The flag is never set in this state, however long the timer waits.
- R5: With a prescale select n from 1 to 7 and a modulus select m, the flag is set exactly 2^(BASE_SHIFT+n)·(m+1) oscillator edges after the write edge. It is set again at the same interval after that (BASE_SHIFT defaults to 9).
- R6: The flag stays set until a clear pulse arrives. A clear pulse in a cycle with no terminal count drops the flag at the next edge.
- R7: When a clear pulse and a terminal count fall in the same cycle, the flag stays set.
- R8: While pseudo-stop is high and the run-in-stop bit is 0, both stages hold their counts. The flag is therefore delayed by exactly the number of frozen cycles.
- R9: While pseudo-stop is high and the run-in-stop bit is 1, the timer keeps its normal period.
- R10: The run-in-stop bit is loaded from its own data input on its own write strobe, at any time. Its value is visible on a dedicated output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that drives the dividers |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control write data |
| regRdEn | input | 1 | Control register read strobe |
| regRdData | output | 8 | Control read data |
| stopRunWrEn | input | 1 | Write strobe for the run-in-stop bit |
| stopRunWrData | input | 1 | New value for the run-in-stop bit |
| stopRunBit | output | 1 | Current run-in-stop bit |
| pseudoStop | input | 1 | Pseudo-stop mode active |
| flagClr | input | 1 | Software clear pulse for the flag |
| irqFlag | output | 1 | Sticky periodic interrupt flag |

## Verification
Two events can land on the same edge: the terminal count that sets the flag and a software clear pulse. The bench lets the flag stay set from one period. It then times a clear pulse so that it arrives exactly on the edge of the next terminal count. After that edge the flag must still be 1. One cycle later, with the clear still high and no terminal count, the flag must read 0. This shows that the set has priority, and that the clear still works on its own.

// File: rtl/periodic_irq_timer_pkg.sv
package periodic_irq_timer_pkg;
  localparam int DATA_W    = 8;
  localparam int PRE_SEL_W = 3;
  localparam int MOD_W     = 4;
  localparam int CTRL_W    = PRE_SEL_W + MOD_W;

  typedef struct packed {
    logic restart;
    logic advance;
  } dpCmd_t;
endpackage

// File: rtl/periodic_irq_timer_ctrl.sv
module periodic_irq_timer_ctrl
  import periodic_irq_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 regRdEn,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 stopRunWrEn,
  input  logic                 stopRunWrData,
  output logic                 stopRunBit,
  input  logic                 pseudoStop,
  input  logic                 flagClr,
  input  logic                 terminal,
  output dpCmd_t               cmd,
  output logic [PRE_SEL_W-1:0] preSel,
  output logic [MOD_W-1:0]     modSel,
  output logic                 irqFlag
);
  logic [CTRL_W-1:0] ctrlReg;
  logic              frozen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (regWrEn) begin
      ctrlReg <= regWrData[CTRL_W-1:0];
    end
  end

  generate
    if (DATA_W > CTRL_W) begin : g_pad
      logic unusedWrBits;
      assign unusedWrBits = ^regWrData[DATA_W-1:CTRL_W];
      assign regRdData = regRdEn ? {{(DATA_W-CTRL_W){1'b0}}, ctrlReg} : '0;
    end else begin : g_nopad
      assign regRdData = regRdEn ? ctrlReg : '0;
    end
  endgenerate

  assign preSel = ctrlReg[CTRL_W-1:MOD_W];
  assign modSel = ctrlReg[MOD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopRunBit <= 1'b0;
    end else if (stopRunWrEn) begin
      stopRunBit <= stopRunWrData;
    end
  end

  assign frozen      = pseudoStop && !stopRunBit;
  assign cmd.restart = regWrEn;
  assign cmd.advance = (preSel != '0) && !frozen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (terminal) begin
      irqFlag <= 1'b1;
    end else if (flagClr) begin
      irqFlag <= 1'b0;
    end
  end

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !flagClr |=> irqFlag);
  assert_flag_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    flagClr && !terminal |=> !irqFlag);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    terminal && flagClr |=> irqFlag);
  assert_stoprun_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopRunWrEn |=> stopRunBit == $past(stopRunWrData));
endmodule

// File: rtl/periodic_irq_timer_dp.sv
module periodic_irq_timer_dp
  import periodic_irq_timer_pkg::*;
#(
  parameter int BASE_SHIFT = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCmd_t               cmd,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic [MOD_W-1:0]     modSel,
  output logic                 terminal
);
  localparam int PRE_W = BASE_SHIFT + (1 << PRE_SEL_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic [MOD_W-1:0] modCnt;
  logic             preTick;

  assign preLimit = (PRE_W'(1) << (BASE_SHIFT + int'(preSel))) - PRE_W'(1);
  assign preTick  = cmd.advance && (preCnt == preLimit);
  assign terminal = preTick && (modCnt == modSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      modCnt <= '0;
    end else if (cmd.restart) begin
      preCnt <= '0;
      modCnt <= '0;
    end else if (cmd.advance) begin
      preCnt <= preTick ? '0 : preCnt + PRE_W'(1);
      if (preTick) begin
        modCnt <= terminal ? '0 : modCnt + MOD_W'(1);
      end
    end
  end

  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (preCnt == '0) && (modCnt == '0));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (preSel == '0) |-> !terminal);
  assert_pre_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt <= preLimit) && (modCnt <= modSel));
  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.advance && !cmd.restart |=> $stable(preCnt) && $stable(modCnt));
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
  import periodic_irq_timer_pkg::*;
#(
  parameter int BASE_SHIFT = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  logic        regRdEn,
  output logic [7:0]  regRdData,
  input  logic        stopRunWrEn,
  input  logic        stopRunWrData,
  output logic        stopRunBit,
  input  logic        pseudoStop,
  input  logic        flagClr,
  output logic        irqFlag
);
  dpCmd_t               cmd;
  logic [PRE_SEL_W-1:0] preSel;
  logic [MOD_W-1:0]     modSel;
  logic                 terminal;

  periodic_irq_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .stopRunWrEn(stopRunWrEn), .stopRunWrData(stopRunWrData),
    .stopRunBit(stopRunBit), .pseudoStop(pseudoStop),
    .flagClr(flagClr), .terminal(terminal), .cmd(cmd),
    .preSel(preSel), .modSel(modSel), .irqFlag(irqFlag)
  );

  periodic_irq_timer_dp #(.BASE_SHIFT(BASE_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .preSel(preSel), .modSel(modSel), .terminal(terminal)
  );
endmodule

// File: tb/periodic_irq_timer_tb.sv
module periodic_irq_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic stopRunWrEn = 1'b0;
  logic stopRunWrData = 1'b0;
  logic stopRunBit;
  logic pseudoStop = 1'b0;
  logic flagClr = 1'b0;
  logic irqFlag;

  int testCount = 0;
  int failCount = 0;
  int cycleCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_irq_timer #(.BASE_SHIFT(BASE)) u_dut (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .stopRunWrEn(stopRunWrEn), .stopRunWrData(stopRunWrData),
    .stopRunBit(stopRunBit), .pseudoStop(pseudoStop),
    .flagClr(flagClr), .irqFlag(irqFlag)
  );

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount == WATCHDOG) begin
      failCount = failCount + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycleCount, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  function automatic int expPeriod(int p, int m);
    return (1 << (BASE + p)) * (m + 1);
  endfunction

  function automatic logic [7:0] expRead(logic [7:0] v);
    return {1'b0, v[6:0]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCtrl(logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setStopRun(logic b);
    @(negedge clk);
    stopRunWrEn = 1'b1;
    stopRunWrData = b;
    @(negedge clk);
    stopRunWrEn = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic setup(logic [7:0] v);
    writeCtrl(8'h00);
    clearFlag();
    writeCtrl(v);
  endtask

  task automatic waitFlag(int limit, inout int n);
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (irqFlag) break;
    end
  endtask

  initial begin
    int n;
    int p;
    int m;
    int per;
    logic [7:0] v;
    void'($urandom(32'h5eed1234));

    repeat (3) @(negedge clk);
    regRdEn = 1'b1;
    #1;
    check(irqFlag == 1'b0, "R1 flag", irqFlag, 0);
    check(stopRunBit == 1'b0, "R1 runbit", stopRunBit, 0);
    check(regRdData == 8'h00, "R1 ctrl", regRdData, 0);
    regRdEn = 1'b0;
    rstN = 1'b1;

    // R2 register access
    for (int i = 0; i < 6; i++) begin
      v = 8'($urandom);
      if (i == 0) v = 8'hFF;
      writeCtrl(v);
      regRdEn = 1'b1;
      #1;
      check(regRdData == expRead(v), "R2 read", regRdData, expRead(v));
      regRdEn = 1'b0;
      #1;
      check(regRdData == 8'h00, "R2 no strobe", regRdData, 0);
    end

    // R10 run-in-stop bit
    setStopRun(1'b1);
    check(stopRunBit == 1'b1, "R10 set", stopRunBit, 1);
    setStopRun(1'b0);
    check(stopRunBit == 1'b0, "R10 clr", stopRunBit, 0);

    // R4 disabled timer
    setup(8'h05);
    n = 0;
    waitFlag(3000, n);
    check(irqFlag == 1'b0, "R4 idle", irqFlag, 0);

    // R5, R6 random periods
    for (int i = 0; i < 12; i++) begin
      p = 1 + int'($urandom % 5);
      m = int'($urandom % 16);
      per = expPeriod(p, m);
      setup(8'((p << 4) | m));
      n = 0;
      waitFlag(per + 20, n);
      check(irqFlag && n == per, "R5 first period", n, per);
      flagClr = 1'b1;
      n = 0;
      @(negedge clk);
      n = 1;
      flagClr = 1'b0;
      check(irqFlag == 1'b0, "R6 clear", irqFlag, 0);
      waitFlag(per + 20, n);
      check(irqFlag && n == per, "R5 repeat period", n, per);
      @(negedge clk);
      check(irqFlag == 1'b1, "R6 sticky", irqFlag, 1);
    end

    // R5 largest prescale
    per = expPeriod(7, 0);
    setup(8'h70);
    n = 0;
    waitFlag(per + 20, n);
    check(irqFlag && n == per, "R5 max prescale", n, per);

    // R3 restart on rewrite
    per = expPeriod(2, 3);
    setup(8'h23);
    repeat (40) @(negedge clk);
    writeCtrl(8'h23);
    n = 0;
    waitFlag(per + 20, n);
    check(irqFlag && n == per, "R3 restart", n, per);

    // R7 clear coincident with terminal
    per = expPeriod(1, 1);
    setup(8'h11);
    n = 0;
    waitFlag(per + 20, n);
    check(irqFlag && n == per, "R7 setup period", n, per);
    repeat (per - 1) @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    check(irqFlag == 1'b1, "R7 set wins", irqFlag, 1);
    @(negedge clk);
    flagClr = 1'b0;
    check(irqFlag == 1'b0, "R7 clear after", irqFlag, 0);

    // R8 freeze and hold
    per = expPeriod(2, 2);
    setup(8'h22);
    repeat (20) @(negedge clk);
    pseudoStop = 1'b1;
    repeat (100) @(negedge clk);
    pseudoStop = 1'b0;
    check(irqFlag == 1'b0, "R8 no flag while frozen", irqFlag, 0);
    n = 120;
    waitFlag(per + 200, n);
    check(irqFlag && n == per + 100, "R8 delayed", n, per + 100);

    // R9 keeps running in pseudo-stop
    setStopRun(1'b1);
    setup(8'h22);
    pseudoStop = 1'b1;
    n = 0;
    waitFlag(per + 20, n);
    pseudoStop = 1'b0;
    check(irqFlag && n == per, "R9 running", n, per);
    setStopRun(1'b0);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule